// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven by a single 32-bit control word. The word carries a start count, a command bit that runs or halts the counter, and a 7-bit key. Software arms the watchdog by writing a word with the command bit set. It refreshes the watchdog by writing again before the count runs out.

While the stored command bit is set, a write is taken only when its key is the bitwise inverse of the stored key. Any other write is dropped. Every accepted write stores the whole word, so successive refreshes alternate between a key and its inverse. This keeps a runaway write loop from holding the watchdog off or switching it off.

The counter steps down once per pulse of a slow tick-enable input, which is generated outside the block. When the count first runs out, the block raises a non-maskable interrupt and reloads a short grace count. If that grace count also runs out before an accepted write, the block emits a one-cycle reset request. The system reset logic that consumes this request is outside the block.

Top module: `keyguard_wdt`

## Requirements
- R1: While reset is asserted, and right after it is released, the control readback is 0, the interrupt and the reset request are low, and the counter is halted.
- R2: In the control word, bits [7:0] hold the start count, bit 8 holds the command (1 = run, 0 = halt) and bits [15:9] hold the key. An accepted write stores all 32 bits, and the readback shows them on the cycle after the write.
- R3: When stored bit 8 is 1, a write whose key is not the 7-bit inverse of the stored key is ignored. The readback, the count and the interrupt are unchanged by it.
- R4: When stored bit 8 is 0, a write is accepted whatever its key.
- R5: A start count of 0 behaves as 256 ticks.
- R6: An accepted write with command 1 and start count N runs the counter. The interrupt rises on the cycle after the N-th tick is sampled, and not before.
- R7: An accepted write with command 0 loads the count and halts the counter. No tick then causes an expiry.
- R8: Once the interrupt is high, the GRACE_TICKS-th following tick produces a reset request exactly one cycle long. The interrupt stays high, the counter halts, and no further request follows.
- R9: An accepted write clears the interrupt and returns the block to the first stage. The next expiry then raises the interrupt instead of requesting a reset.
- R10: The count changes only on cycles with the tick input high. Cycles without a tick make no progress.
- R11: When an accepted write and a tick fall in the same cycle, the write wins and the tick does not decrement the freshly loaded count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable pulse from an external prescaler |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to write |
| ctrl_rdata | output | 32 | Stored control word |
| nmi | output | 1 | Non-maskable interrupt, first-stage expiry |
| rst_req | output | 1 | One-cycle reset request, second-stage expiry |

## Verification
Some properties are checked on every cycle. A reset request is always a single cycle and always comes while the interrupt is high. A write with a wrong key while the watchdog is enabled leaves the stored word unchanged. Every accepted write clears the interrupt and stores the written word. The interrupt can only rise after a tick.

Other behaviour needs counting and so is left to the directed scenarios. These cover the exact tick on which each stage expires, the zero-means-256 rule, a halt that survives any number of ticks, and a write that lands on a tick cycle. They also follow the alternation of keys across several refreshes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    // Field positions inside the control word
    localparam int CMD_BIT = 8;
    localparam int KEY_LSB = 9;
    localparam int KEY_W   = 7;
    localparam int WORD_W  = 32;

    typedef enum logic {
        STG_WATCH = 1'b0,
        STG_GRACE = 1'b1
    } wdt_stage_e;
endpackage

// File: rtl/wdt_key_gate.sv
module wdt_key_gate
    import wdt_pkg::*;
#(
    parameter int START_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [WORD_W-1:0]  ctrl,
    output logic               accept,
    output logic [START_W:0]   load_count,
    output logic               load_run
);
    localparam int CNT_W = START_W + 1;
    localparam logic [CNT_W-1:0] ZERO_AS = CNT_W'(1) << START_W;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        stored_en;
    logic        key_ok;
    logic [START_W-1:0] start_field;

    always_comb begin
        st_d        = st_q;
        stored_en   = st_q.ctrl[CMD_BIT];
        key_ok      = !stored_en ||
                      (wr_data[KEY_LSB +: KEY_W] == ~st_q.ctrl[KEY_LSB +: KEY_W]);
        accept      = wr_en && key_ok;
        start_field = wr_data[START_W-1:0];
        load_count  = (start_field == '0) ? ZERO_AS : {1'b0, start_field};
        load_run    = wr_data[CMD_BIT];
        if (accept) begin
            st_d.ctrl = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = st_q.ctrl;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W       = 9,
    parameter int GRACE_TICKS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_run,
    input  logic             tick,
    input  logic             in_grace,
    output logic             expire
);
    localparam logic [CNT_W-1:0] GRACE_VAL = CNT_W'(GRACE_TICKS);
    localparam logic [CNT_W-1:0] LAST_VAL  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = !load && tick && st_q.run && (st_q.count == LAST_VAL);
        if (load) begin
            st_d.count = load_val;
            st_d.run   = load_run;
        end else if (expire) begin
            if (in_grace) begin
                st_d.count = '0;
                st_d.run   = 1'b0;
            end else begin
                st_d.count = GRACE_VAL;
            end
        end else if (tick && st_q.run) begin
            st_d.count = st_q.count - LAST_VAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic expire,
    output logic in_grace,
    output logic nmi,
    output logic rst_req
);
    typedef struct packed {
        wdt_stage_e stage;
        logic       req;
    } stage_state_t;

    stage_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (clear) begin
            st_d.stage = STG_WATCH;
        end else if (expire) begin
            if (st_q.stage == STG_WATCH) begin
                st_d.stage = STG_GRACE;
            end else begin
                st_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stage: STG_WATCH, req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_grace = (st_q.stage == STG_GRACE);
    assign nmi      = in_grace;
    assign rst_req  = st_q.req;
endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt #(
    parameter int START_W     = 8,
    parameter int GRACE_TICKS = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] ctrl_rdata,
    output logic        nmi,
    output logic        rst_req
);
    localparam int CNT_W = START_W + 1;

    logic             accept;
    logic [CNT_W-1:0] load_count;
    logic             load_run;
    logic             expire;
    logic             in_grace;

    wdt_key_gate #(.START_W(START_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ctrl       (ctrl_rdata),
        .accept     (accept),
        .load_count (load_count),
        .load_run   (load_run)
    );

    wdt_counter #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE_TICKS)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (load_count),
        .load_run (load_run),
        .tick     (tick),
        .in_grace (in_grace),
        .expire   (expire)
    );

    wdt_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .expire   (expire),
        .in_grace (in_grace),
        .nmi      (nmi),
        .rst_req  (rst_req)
    );
endmodule

// File: rtl/keyguard_wdt_chk.sv
module keyguard_wdt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] ctrl_rdata,
    input logic        nmi,
    input logic        rst_req
);
    logic key_match;
    assign key_match = (wr_data[15:9] == ~ctrl_rdata[15:9]);

    assert_req_in_grace_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> nmi);

    assert_req_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_bad_key_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_rdata[8] && !key_match) |=> $stable(ctrl_rdata));

    assert_accept_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (!ctrl_rdata[8] || key_match)) |=> (!nmi && ctrl_rdata == $past(wr_data)));

    assert_nmi_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> $past(tick));
endmodule

bind keyguard_wdt keyguard_wdt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ctrl_rdata (ctrl_rdata),
    .nmi        (nmi),
    .rst_req    (rst_req)
);

// File: tb/keyguard_wdt_bench.sv
`timescale 1ns/1ps
module keyguard_wdt_bench;
    localparam int GRACE = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_rdata;
    logic        nmi;
    logic        rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    keyguard_wdt #(.START_W(8), .GRACE_TICKS(GRACE)) u_keyguard_wdt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .ctrl_rdata(ctrl_rdata), .nmi(nmi), .rst_req(rst_req)
    );

    function automatic logic [31:0] mk(input logic [6:0] key, input logic cmd,
                                       input logic [7:0] cnt, input logic [15:0] hi);
        return {hi, key, cmd, cnt};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] w, input logic with_tick);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w; tick = with_tick;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        check("R1 ctrl in reset", ctrl_rdata, 32'h0);
        check("R1 nmi in reset", {31'b0, nmi}, 32'h0);
        rst_n = 1'b1;
        idle(2);
        check("R1 ctrl after reset", ctrl_rdata, 32'h0);
        check("R1 req after reset", {31'b0, rst_req}, 32'h0);
        for (int i = 0; i < 300; i++) pulse_tick();
        check("R1 halted after reset", {31'b0, nmi}, 32'h0);
    endtask

    task automatic t_arm_and_expire();
        logic [31:0] w;
        w = mk(7'h15, 1'b1, 8'd5, 16'hA5C3);
        do_write(w, 1'b0);
        check("R2 R4 readback", ctrl_rdata, w);
        for (int i = 0; i < 4; i++) pulse_tick();
        check("R6 no nmi before Nth tick", {31'b0, nmi}, 32'h0);
        idle(30);
        check("R10 idle cycles make no progress", {31'b0, nmi}, 32'h0);
        pulse_tick();
        check("R6 nmi on Nth tick", {31'b0, nmi}, 32'h1);
    endtask

    task automatic t_grace();
        int seen;
        for (int i = 0; i < GRACE - 1; i++) pulse_tick();
        check("R8 no req before grace end", {31'b0, rst_req}, 32'h0);
        pulse_tick();
        check("R8 req at grace end", {31'b0, rst_req}, 32'h1);
        idle(1);
        check("R8 req one cycle", {31'b0, rst_req}, 32'h0);
        check("R8 nmi stays", {31'b0, nmi}, 32'h1);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            pulse_tick();
            if (rst_req) seen++;
        end
        check("R8 no further req", seen, 0);
    endtask

    task automatic t_keys();
        logic [31:0] good;
        do_write(mk(7'h15, 1'b1, 8'd3, 16'h0), 1'b0);
        check("R3 bad key readback", ctrl_rdata, mk(7'h15, 1'b1, 8'd5, 16'hA5C3));
        check("R3 bad key nmi kept", {31'b0, nmi}, 32'h1);
        good = mk(7'h6A, 1'b1, 8'd3, 16'h0);
        do_write(good, 1'b0);
        check("R9 good key readback", ctrl_rdata, good);
        check("R9 nmi cleared", {31'b0, nmi}, 32'h0);
        pulse_tick(); pulse_tick();
        check("R9 no early nmi", {31'b0, nmi}, 32'h0);
        pulse_tick();
        check("R9 first stage again nmi", {31'b0, nmi}, 32'h1);
        check("R9 first stage no req", {31'b0, rst_req}, 32'h0);
    endtask

    task automatic t_halt_and_zero();
        logic [31:0] w;
        do_write(mk(7'h15, 1'b0, 8'd2, 16'h0), 1'b0);
        check("R7 nmi cleared on halt write", {31'b0, nmi}, 32'h0);
        for (int i = 0; i < 40; i++) pulse_tick();
        check("R7 halted no nmi", {31'b0, nmi}, 32'h0);
        check("R7 halted no req", {31'b0, rst_req}, 32'h0);
        w = mk(7'h00, 1'b1, 8'd0, 16'h0);
        do_write(w, 1'b0);
        check("R4 any key while disabled", ctrl_rdata, w);
        for (int i = 0; i < 255; i++) pulse_tick();
        check("R5 no nmi at 255", {31'b0, nmi}, 32'h0);
        pulse_tick();
        check("R5 nmi at 256", {31'b0, nmi}, 32'h1);
    endtask

    task automatic t_write_vs_tick();
        do_write(mk(7'h7F, 1'b1, 8'd2, 16'h0), 1'b1);
        check("R11 nmi cleared", {31'b0, nmi}, 32'h0);
        pulse_tick();
        check("R11 tick ignored during write", {31'b0, nmi}, 32'h0);
        pulse_tick();
        check("R11 expiry on second tick", {31'b0, nmi}, 32'h1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_arm_and_expire();
        t_grace();
        t_keys();
        t_halt_and_zero();
        t_write_vs_tick();
        t_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule